// File: doc/BRIEF.md
# Rectangle Copy Blit Engine

This block moves a rectangle of 32-bit pixels from one place in a word-addressed video memory to another. Software sets up a register set before the run: source and destination coordinates, a shared width and height, byte pitches, byte base offsets, two per-axis direction flags, a pixel-format code and a raster-operation code. It then pulses `start`. The engine checks the request. A valid request is carried out one pixel at a time: a read from the source rectangle, then a write of the same word to the destination rectangle. At the end the engine pulses `done` and updates the destination coordinate outputs.

The direction flags choose the corner the walk starts from. An overlapping copy can therefore run right-to-left or bottom-to-top and still give the same result as a copy through a temporary buffer, without one. A request that cannot be served is rejected with an error code and does not touch memory. One build option adds a display offset, masked to 27 bits, to both base addresses.

The memory side uses two valid/ready channels, a read-request channel and a write channel. Back-pressure rules: while a request's valid is high and ready is low, the engine holds the request unchanged. A request counts as accepted only in a cycle where valid and ready are both high. Read data comes back on `rd_rsp_valid`/`rd_rsp_data` at any later cycle and is always accepted. Only one read is ever outstanding.

Top module: `blit_copy_engine`

## Requirements
- R1: Horizontal order. With `dir_ltr`=1 the walk starts at column `dst_x` (source column `src_x`) and moves up by one column per pixel. With `dir_ltr`=0 that register value is the rightmost column and the walk moves down. The lowest column is x+1-width, computed modulo 2^16.
- R2: Vertical order. The walk is row-major, with columns inner. `dir_ttb` picks the first row and the row step the same way `dir_ltr` does for columns, using `dst_y`/`src_y` and the height. Source and destination share the flags, the width and the height.
- R3: With `own_pitch`=1 the source uses `src_pitch`/`src_base` and the destination uses `dst_pitch`/`dst_base`. With `own_pitch`=0 both sides use `dflt_pitch`/`dflt_base`.
- R4: One pixel is one 32-bit word. Word address = base/4 + y*(pitch/4) + x, taken modulo 2^ADDR_W. When USE_DISP_OFFSET=1, (`disp_offset` AND 0x07FFFFFF) is added to both byte bases.
- R5: Bits 3:0 of `dtype` must equal 6 (32-bit pixels). Any other value gives error code 1.
- R6: Bits 23:16 of `rop_mix` must equal 0xCC (source copy). Any other value gives error code 2.
- R7: An effective pitch below 4 bytes, on either side, gives error code 3.
- R8: A lowest start coordinate above 0x3FFF on either side, or a byte base + (lowest y + height)*pitch that is at least 4*2^ADDR_W on either side, gives error code 4. When several errors apply, the lowest code wins. A rejected request makes no memory access.
- R9: After a successful run, `new_dst_x` = lowest column + width if `dir_ltr`=1, else the lowest column. `new_dst_y` follows the same rule with rows. A rejected request leaves both outputs unchanged. Both are 0 after reset.
- R10: `done` is high for exactly one cycle per accepted start. In that cycle `err`/`err_code` report the outcome (code 0 = success). `busy` is high from the cycle after start until `done`. A `start` seen while busy is ignored.
- R11: Requests are held stable under back-pressure. Each destination write carries the word read for the matching source pixel, so an overlapping copy is correct when the direction flags point away from the overlap.
- R12: A width or height of zero makes no memory access. It ends with `done` and no error, and updates the coordinates as in R9.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Start strobe, sampled when idle |
| dir_ltr | input | 1 | 1 = walk columns upward |
| dir_ttb | input | 1 | 1 = walk rows upward |
| own_pitch | input | 1 | 1 = dedicated pitch/base registers |
| dtype | input | 8 | Pixel-format register, bits 3:0 decoded |
| rop_mix | input | 32 | Mix register, ROP in bits 23:16 |
| src_x | input | 16 | Source x register |
| src_y | input | 16 | Source y register |
| dst_x | input | 16 | Destination x register |
| dst_y | input | 16 | Destination y register |
| width | input | 16 | Width in pixels |
| height | input | 16 | Height in rows |
| src_pitch | input | 16 | Source pitch, bytes |
| dst_pitch | input | 16 | Destination pitch, bytes |
| dflt_pitch | input | 16 | Shared default pitch, bytes |
| src_base | input | 32 | Source base, bytes |
| dst_base | input | 32 | Destination base, bytes |
| dflt_base | input | 32 | Shared default base, bytes |
| disp_offset | input | 32 | Display offset (used when USE_DISP_OFFSET=1) |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | Request rejected (valid with done) |
| err_code | output | 3 | Outcome code (valid with done) |
| new_dst_x | output | 16 | Written-back destination x |
| new_dst_y | output | 16 | Written-back destination y |
| rd_req_valid | output | 1 | Read request valid |
| rd_req_ready | input | 1 | Read request ready |
| rd_req_addr | output | ADDR_W | Read word address |
| rd_rsp_valid | input | 1 | Read data valid |
| rd_rsp_data | input | 32 | Read data |
| wr_valid | output | 1 | Write valid |
| wr_ready | input | 1 | Write ready |
| wr_addr | output | ADDR_W | Write word address |
| wr_data | output | 32 | Write data |

## Verification
The copy is tried with all four combinations of direction flags, over disjoint regions and over regions that overlap inside one buffer, and with both dedicated and shared pitch/base sources. A wrong start corner, a wrong step sign or a mixed-up register source shows up as a mismatch when the whole memory is compared with a model that applies writes in the required order. The error paths are tried one at a time, with wrapped and oversized coordinates, and then combined to check the error priority. Those runs separate a clean rejection from a partial copy and from a wrong error code. Random ready gaps on both memory channels, a masked display offset, a zero-size rectangle and a second start during a run each catch their own class of fault.

// File: rtl/blit_pkg.sv
package blit_pkg;
  localparam int PIX_W   = 32;
  localparam int COORD_W = 16;
  localparam int PITCH_W = 16;
  localparam int BASE_W  = 32;

  localparam logic [3:0]         DTYPE_ARGB32 = 4'd6;
  localparam logic [7:0]         ROP_SRCCOPY  = 8'hCC;
  localparam logic [COORD_W-1:0] COORD_MAX    = 16'h3FFF;
  localparam logic [BASE_W-1:0]  DISP_MASK    = 32'h07FF_FFFF;

  typedef enum logic [2:0] {
    ERR_NONE  = 3'd0,
    ERR_DTYPE = 3'd1,
    ERR_ROP   = 3'd2,
    ERR_PITCH = 3'd3,
    ERR_RANGE = 3'd4
  } blit_err_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RDREQ,
    ST_RDWAIT,
    ST_WRITE,
    ST_DONE
  } blit_state_e;
endpackage

// File: rtl/blit_setup.sv
module blit_setup
  import blit_pkg::*;
#(
  parameter int ADDR_W          = 12,
  parameter bit USE_DISP_OFFSET = 1'b0
) (
  input  logic               own_pitch,
  input  logic               dir_ltr,
  input  logic               dir_ttb,
  input  logic [3:0]         dtype_lo,
  input  logic [7:0]         rop,
  input  logic [COORD_W-1:0] src_x,
  input  logic [COORD_W-1:0] src_y,
  input  logic [COORD_W-1:0] dst_x,
  input  logic [COORD_W-1:0] dst_y,
  input  logic [COORD_W-1:0] width,
  input  logic [COORD_W-1:0] height,
  input  logic [PITCH_W-1:0] src_pitch,
  input  logic [PITCH_W-1:0] dst_pitch,
  input  logic [PITCH_W-1:0] dflt_pitch,
  input  logic [BASE_W-1:0]  src_base,
  input  logic [BASE_W-1:0]  dst_base,
  input  logic [BASE_W-1:0]  dflt_base,
  input  logic [BASE_W-1:0]  disp_offset,
  output blit_err_e          err,
  output logic               empty,
  output logic [BASE_W-2:0]  src_wbase,
  output logic [BASE_W-2:0]  dst_wbase,
  output logic [PITCH_W-3:0] src_wstride,
  output logic [PITCH_W-3:0] dst_wstride,
  output logic [COORD_W-1:0] wb_x,
  output logic [COORD_W-1:0] wb_y
);
  localparam int SUM_W = 40;
  localparam logic [SUM_W-1:0] MEM_BYTES = SUM_W'(4) << ADDR_W;

  logic [BASE_W-1:0]  disp_add;
  logic [BASE_W:0]    s_base, d_base;
  logic [PITCH_W-1:0] s_pitch, d_pitch;
  logic [COORD_W-1:0] s_lo_x, s_lo_y, d_lo_x, d_lo_y;

  generate
    if (USE_DISP_OFFSET) begin : g_disp
      assign disp_add = disp_offset & DISP_MASK;
    end else begin : g_nodisp
      logic unused_disp;
      assign unused_disp = ^disp_offset;
      assign disp_add    = '0;
    end
  endgenerate

  assign s_base  = {1'b0, own_pitch ? src_base : dflt_base} + {1'b0, disp_add};
  assign d_base  = {1'b0, own_pitch ? dst_base : dflt_base} + {1'b0, disp_add};
  assign s_pitch = own_pitch ? src_pitch : dflt_pitch;
  assign d_pitch = own_pitch ? dst_pitch : dflt_pitch;

  assign s_lo_x = dir_ltr ? src_x : src_x + 16'd1 - width;
  assign s_lo_y = dir_ttb ? src_y : src_y + 16'd1 - height;
  assign d_lo_x = dir_ltr ? dst_x : dst_x + 16'd1 - width;
  assign d_lo_y = dir_ttb ? dst_y : dst_y + 16'd1 - height;

  function automatic logic past_end(input logic [BASE_W:0] base,
                                    input logic [COORD_W-1:0] lo_y,
                                    input logic [COORD_W-1:0] h,
                                    input logic [PITCH_W-1:0] pitch);
    logic [SUM_W-1:0] rows, span;
    rows = SUM_W'(lo_y) + SUM_W'(h);
    span = SUM_W'(base) + rows * SUM_W'(pitch);
    return span >= MEM_BYTES;
  endfunction

  logic bad_coord, bad_span;
  assign bad_coord = (s_lo_x > COORD_MAX) || (s_lo_y > COORD_MAX) ||
                     (d_lo_x > COORD_MAX) || (d_lo_y > COORD_MAX);
  assign bad_span  = past_end(s_base, s_lo_y, height, s_pitch) ||
                     past_end(d_base, d_lo_y, height, d_pitch);

  always_comb begin
    if (dtype_lo != DTYPE_ARGB32)                               err = ERR_DTYPE;
    else if (rop != ROP_SRCCOPY)                                err = ERR_ROP;
    else if (s_pitch[PITCH_W-1:2] == '0 || d_pitch[PITCH_W-1:2] == '0) err = ERR_PITCH;
    else if (bad_coord || bad_span)                             err = ERR_RANGE;
    else                                                        err = ERR_NONE;
  end

  assign empty       = (width == '0) || (height == '0);
  assign src_wbase   = s_base[BASE_W:2];
  assign dst_wbase   = d_base[BASE_W:2];
  assign src_wstride = s_pitch[PITCH_W-1:2];
  assign dst_wstride = d_pitch[PITCH_W-1:2];
  assign wb_x        = dir_ltr ? d_lo_x + width  : d_lo_x;
  assign wb_y        = dir_ttb ? d_lo_y + height : d_lo_y;
endmodule

// File: rtl/blit_walker.sv
module blit_walker
  import blit_pkg::*;
#(
  parameter int ADDR_W = 12
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               load,
  input  logic               step,
  input  logic               dir_ltr,
  input  logic               dir_ttb,
  input  logic [COORD_W-1:0] first_sx,
  input  logic [COORD_W-1:0] first_sy,
  input  logic [COORD_W-1:0] first_dx,
  input  logic [COORD_W-1:0] first_dy,
  input  logic [COORD_W-1:0] width,
  input  logic [COORD_W-1:0] height,
  input  logic [BASE_W-2:0]  src_wbase,
  input  logic [BASE_W-2:0]  dst_wbase,
  input  logic [PITCH_W-3:0] src_wstride,
  input  logic [PITCH_W-3:0] dst_wstride,
  output logic [ADDR_W-1:0]  src_addr,
  output logic [ADDR_W-1:0]  dst_addr,
  output logic               last
);
  logic [COORD_W-1:0] sx, sy, dx, dy, sx0, dx0, w_q, col_left, row_left;
  logic               ltr_q, ttb_q;
  logic [BASE_W-2:0]  sbase_q, dbase_q;
  logic [PITCH_W-3:0] sstr_q, dstr_q;
  logic               row_end;

  assign row_end = (col_left == 16'd1);
  assign last    = row_end && (row_left == 16'd1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sx <= '0; sy <= '0; dx <= '0; dy <= '0;
      sx0 <= '0; dx0 <= '0; w_q <= '0;
      col_left <= '0; row_left <= '0;
      ltr_q <= 1'b1; ttb_q <= 1'b1;
      sbase_q <= '0; dbase_q <= '0; sstr_q <= '0; dstr_q <= '0;
    end else if (load) begin
      sx <= first_sx; sy <= first_sy; dx <= first_dx; dy <= first_dy;
      sx0 <= first_sx; dx0 <= first_dx; w_q <= width;
      col_left <= width; row_left <= height;
      ltr_q <= dir_ltr; ttb_q <= dir_ttb;
      sbase_q <= src_wbase; dbase_q <= dst_wbase;
      sstr_q <= src_wstride; dstr_q <= dst_wstride;
    end else if (step) begin
      if (row_end) begin
        sx       <= sx0;
        dx       <= dx0;
        col_left <= w_q;
        row_left <= row_left - 16'd1;
        sy       <= ttb_q ? sy + 16'd1 : sy - 16'd1;
        dy       <= ttb_q ? dy + 16'd1 : dy - 16'd1;
      end else begin
        col_left <= col_left - 16'd1;
        sx       <= ltr_q ? sx + 16'd1 : sx - 16'd1;
        dx       <= ltr_q ? dx + 16'd1 : dx - 16'd1;
      end
    end
  end

  logic [31:0] s_full, d_full;
  assign s_full = 32'(sbase_q) + 32'(sy) * 32'(sstr_q) + 32'(sx);
  assign d_full = 32'(dbase_q) + 32'(dy) * 32'(dstr_q) + 32'(dx);
  assign src_addr = s_full[ADDR_W-1:0];
  assign dst_addr = d_full[ADDR_W-1:0];

  logic unused_hi;
  assign unused_hi = ^{s_full[31:ADDR_W], d_full[31:ADDR_W]};

  // R1: column step follows the latched horizontal flag
  a_r1_col_step: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !load && !row_end) |=>
      (dx == ($past(ltr_q) ? $past(dx) + 16'd1 : $past(dx) - 16'd1)));

  // R2: row step follows the latched vertical flag and rewinds the column
  a_r2_row_step: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !load && row_end) |=>
      ((dy == ($past(ttb_q) ? $past(dy) + 16'd1 : $past(dy) - 16'd1)) && (dx == dx0)));
endmodule

// File: rtl/blit_copy_engine.sv
module blit_copy_engine
  import blit_pkg::*;
#(
  parameter int ADDR_W          = 12,
  parameter bit USE_DISP_OFFSET = 1'b0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              dir_ltr,
  input  logic              dir_ttb,
  input  logic              own_pitch,
  input  logic [7:0]        dtype,
  input  logic [31:0]       rop_mix,
  input  logic [15:0]       src_x,
  input  logic [15:0]       src_y,
  input  logic [15:0]       dst_x,
  input  logic [15:0]       dst_y,
  input  logic [15:0]       width,
  input  logic [15:0]       height,
  input  logic [15:0]       src_pitch,
  input  logic [15:0]       dst_pitch,
  input  logic [15:0]       dflt_pitch,
  input  logic [31:0]       src_base,
  input  logic [31:0]       dst_base,
  input  logic [31:0]       dflt_base,
  input  logic [31:0]       disp_offset,
  output logic              busy,
  output logic              done,
  output logic              err,
  output logic [2:0]        err_code,
  output logic [15:0]       new_dst_x,
  output logic [15:0]       new_dst_y,
  output logic              rd_req_valid,
  input  logic              rd_req_ready,
  output logic [ADDR_W-1:0] rd_req_addr,
  input  logic              rd_rsp_valid,
  input  logic [31:0]       rd_rsp_data,
  output logic              wr_valid,
  input  logic              wr_ready,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [31:0]       wr_data
);
  blit_err_e          chk_err;
  logic               chk_empty;
  logic [BASE_W-2:0]  s_wbase, d_wbase;
  logic [PITCH_W-3:0] s_wstride, d_wstride;
  logic [COORD_W-1:0] wb_x, wb_y;

  logic unused_cfg;
  assign unused_cfg = ^{dtype[7:4], rop_mix[31:24], rop_mix[15:0]};

  blit_setup #(.ADDR_W(ADDR_W), .USE_DISP_OFFSET(USE_DISP_OFFSET)) u_setup (
    .own_pitch(own_pitch), .dir_ltr(dir_ltr), .dir_ttb(dir_ttb),
    .dtype_lo(dtype[3:0]), .rop(rop_mix[23:16]),
    .src_x(src_x), .src_y(src_y), .dst_x(dst_x), .dst_y(dst_y),
    .width(width), .height(height),
    .src_pitch(src_pitch), .dst_pitch(dst_pitch), .dflt_pitch(dflt_pitch),
    .src_base(src_base), .dst_base(dst_base), .dflt_base(dflt_base),
    .disp_offset(disp_offset),
    .err(chk_err), .empty(chk_empty),
    .src_wbase(s_wbase), .dst_wbase(d_wbase),
    .src_wstride(s_wstride), .dst_wstride(d_wstride),
    .wb_x(wb_x), .wb_y(wb_y)
  );

  blit_state_e state;
  blit_err_e   err_q;
  logic [PIX_W-1:0]   data_q;
  logic [COORD_W-1:0] pend_x, pend_y;
  logic               accept, go, w_last, w_step;

  assign accept = (state == ST_IDLE) && start;
  assign go     = accept && (chk_err == ERR_NONE) && !chk_empty;
  assign w_step = (state == ST_WRITE) && wr_ready && !w_last;

  blit_walker #(.ADDR_W(ADDR_W)) u_walker (
    .clk(clk), .rst_n(rst_n), .load(go), .step(w_step),
    .dir_ltr(dir_ltr), .dir_ttb(dir_ttb),
    .first_sx(src_x), .first_sy(src_y), .first_dx(dst_x), .first_dy(dst_y),
    .width(width), .height(height),
    .src_wbase(s_wbase), .dst_wbase(d_wbase),
    .src_wstride(s_wstride), .dst_wstride(d_wstride),
    .src_addr(rd_req_addr), .dst_addr(wr_addr), .last(w_last)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      err_q     <= ERR_NONE;
      data_q    <= '0;
      pend_x    <= '0;
      pend_y    <= '0;
      new_dst_x <= '0;
      new_dst_y <= '0;
    end else begin
      unique case (state)
        ST_IDLE: if (accept) begin
          err_q  <= chk_err;
          pend_x <= wb_x;
          pend_y <= wb_y;
          if (go) begin
            state <= ST_RDREQ;
          end else begin
            state <= ST_DONE;
            if (chk_err == ERR_NONE) begin
              new_dst_x <= wb_x;
              new_dst_y <= wb_y;
            end
          end
        end
        ST_RDREQ:  if (rd_req_ready) state <= ST_RDWAIT;
        ST_RDWAIT: if (rd_rsp_valid) begin
          data_q <= rd_rsp_data;
          state  <= ST_WRITE;
        end
        ST_WRITE: if (wr_ready) begin
          if (w_last) begin
            state     <= ST_DONE;
            new_dst_x <= pend_x;
            new_dst_y <= pend_y;
          end else begin
            state <= ST_RDREQ;
          end
        end
        ST_DONE: state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign busy         = (state != ST_IDLE);
  assign done         = (state == ST_DONE);
  assign err          = done && (err_q != ERR_NONE);
  assign err_code     = err_q;
  assign rd_req_valid = (state == ST_RDREQ);
  assign wr_valid     = (state == ST_WRITE);
  assign wr_data      = data_q;

  // R11: a stalled read request keeps its address
  a_r11_rd_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req_valid && !rd_req_ready) |=> (rd_req_valid && $stable(rd_req_addr)));

  // R11: a stalled write keeps address and data
  a_r11_wr_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && !wr_ready) |=> (wr_valid && $stable(wr_addr) && $stable(wr_data)));

  // R10: completion is a single-cycle pulse followed by idle
  a_r10_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> (!done && !busy));

  // R9: coordinate outputs move only on the edge that enters completion
  a_r9_wb_timing: assert property (@(posedge clk) disable iff (!rst_n)
    (!done && !$stable(new_dst_x)) |-> 1'b0);
endmodule

// File: tb/blit_copy_engine_bench.sv
module blit_copy_engine_bench;
  localparam int AW    = 10;
  localparam int WORDS = 1 << AW;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic rst_n, start, dir_ltr, dir_ttb, own_pitch;
  logic [7:0]  dtype;
  logic [31:0] rop_mix, src_base, dst_base, dflt_base, disp_offset;
  logic [15:0] src_x, src_y, dst_x, dst_y, width, height, src_pitch, dst_pitch, dflt_pitch;
  logic busy, done, err;
  logic [2:0] err_code;
  logic [15:0] new_dst_x, new_dst_y;
  logic rd_req_valid, rd_req_ready, rd_rsp_valid, wr_valid, wr_ready;
  logic [AW-1:0] rd_req_addr, wr_addr;
  logic [31:0] rd_rsp_data, wr_data;

  blit_copy_engine #(.ADDR_W(AW), .USE_DISP_OFFSET(1'b1)) u_blit_copy_engine (
    .clk(clk), .rst_n(rst_n), .start(start), .dir_ltr(dir_ltr), .dir_ttb(dir_ttb),
    .own_pitch(own_pitch), .dtype(dtype), .rop_mix(rop_mix),
    .src_x(src_x), .src_y(src_y), .dst_x(dst_x), .dst_y(dst_y),
    .width(width), .height(height), .src_pitch(src_pitch), .dst_pitch(dst_pitch),
    .dflt_pitch(dflt_pitch), .src_base(src_base), .dst_base(dst_base),
    .dflt_base(dflt_base), .disp_offset(disp_offset),
    .busy(busy), .done(done), .err(err), .err_code(err_code),
    .new_dst_x(new_dst_x), .new_dst_y(new_dst_y),
    .rd_req_valid(rd_req_valid), .rd_req_ready(rd_req_ready), .rd_req_addr(rd_req_addr),
    .rd_rsp_valid(rd_rsp_valid), .rd_rsp_data(rd_rsp_data),
    .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_addr(wr_addr), .wr_data(wr_data)
  );

  logic [31:0] mem [WORDS];
  logic [31:0] refm [WORDS];
  int rd_cnt, wr_cnt, done_cnt;
  int tests = 0, fails = 0;
  logic [15:0] exp_nx = '0, exp_ny = '0;

  always @(posedge clk) begin
    rd_rsp_valid <= 1'b0;
    if (rd_req_valid && rd_req_ready) begin
      rd_rsp_data  <= mem[rd_req_addr];
      rd_rsp_valid <= 1'b1;
      rd_cnt       <= rd_cnt + 1;
    end
    if (wr_valid && wr_ready) begin
      mem[wr_addr] <= wr_data;
      wr_cnt       <= wr_cnt + 1;
    end
    if (done) done_cnt <= done_cnt + 1;
  end

  initial begin
    rd_req_ready = 1'b1; wr_ready = 1'b1;
    forever begin
      @(negedge clk);
      rd_req_ready = ($urandom % 4) != 0;
      wr_ready     = ($urandom % 3) != 0;
    end
  end

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic longint eff_base(input logic [31:0] ded, input logic [31:0] dfl);
    return longint'(own_pitch ? ded : dfl) + longint'(disp_offset & 32'h07FF_FFFF);
  endfunction

  function automatic logic [15:0] lo_of(input logic [15:0] v, input logic [15:0] n, input logic fwd);
    return fwd ? v : v + 16'd1 - n;
  endfunction

  function automatic bit past_end(input longint b, input logic [15:0] ly, input logic [15:0] p);
    return b + (longint'(ly) + longint'(height)) * longint'(p) >= longint'(4 * WORDS);
  endfunction

  function automatic logic [2:0] model_err();
    logic [15:0] sp, dp;
    sp = own_pitch ? src_pitch : dflt_pitch;
    dp = own_pitch ? dst_pitch : dflt_pitch;
    if (dtype[3:0] != 4'd6) return 3'd1;
    if (rop_mix[23:16] != 8'hCC) return 3'd2;
    if (sp < 16'd4 || dp < 16'd4) return 3'd3;
    if (lo_of(src_x, width, dir_ltr) > 16'h3FFF || lo_of(src_y, height, dir_ttb) > 16'h3FFF ||
        lo_of(dst_x, width, dir_ltr) > 16'h3FFF || lo_of(dst_y, height, dir_ttb) > 16'h3FFF)
      return 3'd4;
    if (past_end(eff_base(src_base, dflt_base), lo_of(src_y, height, dir_ttb), sp) ||
        past_end(eff_base(dst_base, dflt_base), lo_of(dst_y, height, dir_ttb), dp))
      return 3'd4;
    return 3'd0;
  endfunction

  task automatic model_copy();
    longint sb, db, ss, ds;
    sb = eff_base(src_base, dflt_base) / 4;
    db = eff_base(dst_base, dflt_base) / 4;
    ss = longint'(own_pitch ? src_pitch : dflt_pitch) / 4;
    ds = longint'(own_pitch ? dst_pitch : dflt_pitch) / 4;
    for (int r = 0; r < int'(height); r++) begin
      for (int c = 0; c < int'(width); c++) begin
        logic [15:0] ry_s, ry_d, cx_s, cx_d;
        longint sa, da;
        ry_s = dir_ttb ? src_y + 16'(r) : src_y - 16'(r);
        ry_d = dir_ttb ? dst_y + 16'(r) : dst_y - 16'(r);
        cx_s = dir_ltr ? src_x + 16'(c) : src_x - 16'(c);
        cx_d = dir_ltr ? dst_x + 16'(c) : dst_x - 16'(c);
        sa = (sb + longint'(ry_s) * ss + longint'(cx_s)) % WORDS;
        da = (db + longint'(ry_d) * ds + longint'(cx_d)) % WORDS;
        refm[da] = refm[sa];
      end
    end
  endtask

  task automatic run_op(input string tag, input bit poke);
    logic [2:0] e;
    int guard, bad, d0;
    e = model_err();
    if (e == 3'd0) begin
      model_copy();
      exp_nx = dir_ltr ? lo_of(dst_x, width, 1'b1) + width : lo_of(dst_x, width, 1'b0);
      exp_ny = dir_ttb ? lo_of(dst_y, height, 1'b1) + height : lo_of(dst_y, height, 1'b0);
    end
    @(negedge clk);
    rd_cnt = 0; wr_cnt = 0; d0 = done_cnt;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    guard = 0;
    while (!done && guard < 20000) begin
      if (poke && guard == 2) start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      guard++;
    end
    chk(done, {tag, " R10 done seen"}, done, 1);
    chk(err_code == e, {tag, " err_code"}, err_code, e);
    chk(err == (e != 3'd0), {tag, " R10 err flag"}, err, e != 3'd0);
    if (e != 3'd0)
      chk(rd_cnt == 0 && wr_cnt == 0, {tag, " R8 no access"}, rd_cnt + wr_cnt, 0);
    else
      chk(wr_cnt == int'(width) * int'(height), {tag, " R11 write count"}, wr_cnt,
          int'(width) * int'(height));
    bad = 0;
    for (int i = 0; i < WORDS; i++) if (mem[i] !== refm[i]) bad++;
    chk(bad == 0, {tag, " R11 memory image"}, bad, 0);
    chk(new_dst_x == exp_nx && new_dst_y == exp_ny, {tag, " R9 writeback"},
        {new_dst_x, new_dst_y}, {exp_nx, exp_ny});
    if (poke) begin
      repeat (10) @(negedge clk);
      chk(done_cnt - d0 == 1, {tag, " R10 start while busy ignored"}, done_cnt - d0, 1);
    end
    @(negedge clk);
  endtask

  task automatic base_cfg();
    dir_ltr = 1; dir_ttb = 1; own_pitch = 1; dtype = 8'h06; rop_mix = 32'h00CC_0000;
    src_pitch = 16'd64; dst_pitch = 16'd64; dflt_pitch = 16'd64;
    src_base = 0; dst_base = 32'd2048; dflt_base = 32'd1024; disp_offset = 0;
    src_x = 2; src_y = 3; dst_x = 4; dst_y = 5; width = 4; height = 3;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=%0d expected=%0d", 190000, 0);
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    rd_cnt = 0; wr_cnt = 0; done_cnt = 0;
    for (int i = 0; i < WORDS; i++) begin
      mem[i] = $urandom;
      refm[i] = mem[i];
    end
    rst_n = 0; start = 0;
    base_cfg();
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(!busy && !done && !err, "R10 reset idle", {busy, done, err}, 0);
    chk(new_dst_x == 0 && new_dst_y == 0, "R9 reset coords", {new_dst_x, new_dst_y}, 0);

    base_cfg(); run_op("R1 R2 R3 forward copy", 0);
    base_cfg(); dir_ltr = 0; dir_ttb = 0; src_x = 9; src_y = 8; dst_x = 12; dst_y = 10;
    run_op("R1 R2 reversed copy", 0);
    base_cfg(); own_pitch = 0; dir_ltr = 0; src_x = 7; dst_x = 8; src_y = 2; dst_y = 2; width = 6;
    run_op("R1 R3 overlap shift right", 0);
    base_cfg(); own_pitch = 0; dir_ttb = 0; src_y = 6; dst_y = 7; height = 4;
    run_op("R2 R3 overlap shift down", 0);
    base_cfg(); disp_offset = 32'hF800_0100; run_op("R4 masked display offset", 0);
    base_cfg(); dtype = 8'h13; run_op("R5 bad datatype", 0);
    base_cfg(); rop_mix = 32'h00F0_0000; run_op("R6 unsupported rop", 0);
    base_cfg(); dtype = 8'h02; rop_mix = 32'h0; run_op("R8 priority dtype over rop", 0);
    base_cfg(); dst_pitch = 0; run_op("R7 zero dest pitch", 0);
    base_cfg(); own_pitch = 0; dflt_pitch = 16'd2; run_op("R7 sub-word pitch", 0);
    base_cfg(); dst_x = 16'h4000; run_op("R8 coordinate limit", 0);
    base_cfg(); dir_ltr = 0; src_x = 1; dst_x = 8; run_op("R8 wrapped start column", 0);
    base_cfg(); dst_y = 28; height = 4; run_op("R8 span reaches end", 0);
    base_cfg(); width = 0; dir_ltr = 0; run_op("R12 zero width", 0);
    base_cfg(); height = 0; run_op("R12 zero height", 0);
    base_cfg(); run_op("R10 second start", 1);

    for (int n = 0; n < 24; n++) begin
      base_cfg();
      dir_ltr = $urandom % 2; dir_ttb = $urandom % 2; own_pitch = $urandom % 2;
      width = 16'(1 + $urandom % 6); height = 16'(1 + $urandom % 5);
      src_base = ($urandom % 2) ? 32'd1024 : 32'd0;
      dst_base = ($urandom % 2) ? 32'd2048 : 32'd1024;
      src_x = 16'($urandom % (17 - width)); dst_x = 16'($urandom % (17 - width));
      src_y = 16'($urandom % 10); dst_y = 16'($urandom % 10);
      if (!dir_ltr) begin src_x = src_x + width - 1; dst_x = dst_x + width - 1; end
      if (!dir_ttb) begin src_y = src_y + height - 1; dst_y = dst_y + height - 1; end
      run_op("R1 R2 R4 R11 random", 0);
    end

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule